// File: doc/BRIEF.md
# Isochronous Start-Split Position Sequencer

This block runs the start-split half of a split isochronous OUT transfer on a high-speed USB host. Once per micro-frame the schedule walker hands it a view of the endpoint's transfer descriptor as parallel fields: an active flag, an eight-bit micro-frame selection mask, a remaining split count, the current position code and the number of payload bytes still to send. The block decides whether a start-split goes out in this micro-frame. If one does, it sets how many bytes that start-split carries and which position annotation tags it. It then returns the updated descriptor fields so that they can be stored back.

A payload is cut into chunks of at most 188 bytes. A transfer of one chunk is tagged as a whole transfer. A longer one is tagged as a first chunk, then middle chunks, then a closing chunk. When the host is held off in a micro-frame that the mask selects, the block raises a per-packet skip flag. It leaves the descriptor exactly as it was and does not halt, so the transfer resumes at the next selected micro-frame.

Top module: `iso_ssplit_seq`

## Requirements
- R1: A start-split (`ssIssue`=1 in the cycle after `frameValid`) is issued only when the descriptor is active, its count is non-zero, mask bit number `uframeIdx` is set and `holdOff` is low.
- R2: An issued start-split carries min(`inBytes`, 188) bytes on `ssBytes`; `ssBytes` is 0 when nothing is issued.
- R3: Position codes are ALL=0, BEGIN=1, MID=2, END=3. With a count above 1 the issued code is `inPos`. With a count of exactly 1 the issued code is ALL when `inPos` is ALL, and END otherwise.
- R4: After an issue with a count above 1, the write-back count is the count minus 1 and the write-back bytes are `inBytes` minus the chunk. The write-back position is END if the new count is 1 and MID otherwise, and the descriptor stays active.
- R5: After an issue with a count of 1, the write-back clears the active flag, decrements the count to 0, keeps the issued code as position and subtracts the chunk from the bytes.
- R6: In a selected micro-frame with `holdOff` high, `skipErr` is 1, nothing is issued and every write-back field equals its input.
- R7: In a micro-frame that is not selected (mask bit clear, inactive, or count 0) there is no issue and no error, and every write-back field equals its input.
- R8: A skip error never halts the endpoint: the unchanged write-back, fed back, issues normally at the next selected micro-frame.
- R9: `wbValid` is high exactly one cycle after each `frameValid`. Reset clears `wbValid`, `ssIssue` and `skipErr`, and they stay 0 while no micro-frame is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Descriptor view for one micro-frame is present |
| uframeIdx | input | 3 | Micro-frame number within the frame |
| holdOff | input | 1 | Host could not service the schedule this micro-frame |
| inActive | input | 1 | Descriptor active flag |
| inMask | input | 8 | Micro-frames selected for start-splits |
| inCount | input | 3 | Start-splits remaining |
| inPos | input | 2 | Current position code |
| inBytes | input | 10 | Payload bytes still to send |
| ssIssue | output | 1 | A start-split is issued |
| ssBytes | output | 10 | Bytes carried by the start-split |
| ssPos | output | 2 | Position annotation of the start-split |
| skipErr | output | 1 | Selected micro-frame lost to a hold-off |
| wbValid | output | 1 | Write-back fields valid |
| wbActive | output | 1 | Updated active flag |
| wbCount | output | 3 | Updated count |
| wbPos | output | 2 | Updated position code |
| wbBytes | output | 10 | Updated remaining bytes |

## Verification
Three payload shapes go through the sequencer with the write-back fed back as the next descriptor. A 400-byte, three-split transfer separates the BEGIN/MID/END walk and the partial final chunk from a plain pass-through. A 100-byte single split checks that ALL is kept and the descriptor retires at once. An exactly-188-byte single split probes the chunk boundary and leaves zero bytes. A hold-off on the first selected micro-frame of a two-split transfer shows that the skip flag leaves the descriptor untouched and that the next selected slot starts with BEGIN. Inactive and zero-count descriptors with a full mask show that selection depends on more than the mask.

// File: rtl/iso_ssplit_pkg.sv
package iso_ssplit_pkg;

  typedef enum logic [1:0] {
    POS_ALL   = 2'd0,
    POS_BEGIN = 2'd1,
    POS_MID   = 2'd2,
    POS_END   = 2'd3
  } posCode_t;

  typedef struct packed {
    logic capture;  // a micro-frame view is present
    logic issue;    // emit a start-split now
    logic skip;     // selected slot lost to a hold-off
    logic last;     // this start-split is the final one
  } ctrlStrobe_t;

endpackage

// File: rtl/iso_ssplit_ctrl.sv
module iso_ssplit_ctrl #(
  parameter int UF_N  = 8,
  parameter int UF_W  = $clog2(UF_N)
) (
  input  logic                          frameValid,
  input  logic [UF_W-1:0]               uframeIdx,
  input  logic                          holdOff,
  input  logic                          inActive,
  input  logic [UF_N-1:0]               inMask,
  input  logic                          countNonZero,
  input  logic                          countIsOne,
  output iso_ssplit_pkg::ctrlStrobe_t   strb
);

  logic slotSelected;

  always_comb begin
    slotSelected = frameValid && inActive && countNonZero && inMask[uframeIdx];
    strb.capture = frameValid;
    strb.issue   = slotSelected && !holdOff;
    strb.skip    = slotSelected && holdOff;
    strb.last    = countIsOne;
  end

endmodule

// File: rtl/iso_ssplit_dp.sv
module iso_ssplit_dp #(
  parameter int BYTE_W    = 10,
  parameter int CNT_W     = 3,
  parameter int MAX_CHUNK = 188
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  iso_ssplit_pkg::ctrlStrobe_t   strb,
  input  logic                          inActive,
  input  logic [CNT_W-1:0]              inCount,
  input  logic [1:0]                    inPos,
  input  logic [BYTE_W-1:0]             inBytes,
  output logic                          ssIssue,
  output logic [BYTE_W-1:0]             ssBytes,
  output logic [1:0]                    ssPos,
  output logic                          skipErr,
  output logic                          wbValid,
  output logic                          wbActive,
  output logic [CNT_W-1:0]              wbCount,
  output logic [1:0]                    wbPos,
  output logic [BYTE_W-1:0]             wbBytes
);
  import iso_ssplit_pkg::*;

  localparam logic [BYTE_W-1:0] CHUNK_LIM = BYTE_W'(MAX_CHUNK);
  localparam logic [CNT_W-1:0]  ONE_CNT   = CNT_W'(1);

  logic [BYTE_W-1:0] chunkLen;
  posCode_t          curPos;
  posCode_t          emitPos;
  posCode_t          nextPos;
  logic [CNT_W-1:0]  nextCount;

  always_comb begin
    curPos    = posCode_t'(inPos);
    chunkLen  = (inBytes > CHUNK_LIM) ? CHUNK_LIM : inBytes;
    nextCount = inCount - ONE_CNT;
    if (strb.last)
      emitPos = (curPos == POS_ALL) ? POS_ALL : POS_END;
    else
      emitPos = curPos;
    nextPos = (nextCount == ONE_CNT) ? POS_END : POS_MID;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ssIssue  <= 1'b0;
      ssBytes  <= '0;
      ssPos    <= POS_ALL;
      skipErr  <= 1'b0;
      wbValid  <= 1'b0;
      wbActive <= 1'b0;
      wbCount  <= '0;
      wbPos    <= POS_ALL;
      wbBytes  <= '0;
    end else begin
      wbValid <= strb.capture;
      ssIssue <= strb.issue;
      skipErr <= strb.skip;
      if (strb.issue) begin
        ssBytes  <= chunkLen;
        ssPos    <= emitPos;
        wbCount  <= nextCount;
        wbBytes  <= inBytes - chunkLen;
        wbActive <= !strb.last;
        wbPos    <= strb.last ? emitPos : nextPos;
      end else begin
        ssBytes <= '0;
        ssPos   <= POS_ALL;
        if (strb.capture) begin
          wbActive <= inActive;
          wbCount  <= inCount;
          wbPos    <= inPos;
          wbBytes  <= inBytes;
        end
      end
    end
  end

endmodule

// File: rtl/iso_ssplit_seq.sv
module iso_ssplit_seq #(
  parameter int UF_N      = 8,
  parameter int BYTE_W    = 10,
  parameter int CNT_W     = 3,
  parameter int MAX_CHUNK = 188,
  parameter int UF_W      = $clog2(UF_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [UF_W-1:0]   uframeIdx,
  input  logic              holdOff,
  input  logic              inActive,
  input  logic [UF_N-1:0]   inMask,
  input  logic [CNT_W-1:0]  inCount,
  input  logic [1:0]        inPos,
  input  logic [BYTE_W-1:0] inBytes,
  output logic              ssIssue,
  output logic [BYTE_W-1:0] ssBytes,
  output logic [1:0]        ssPos,
  output logic              skipErr,
  output logic              wbValid,
  output logic              wbActive,
  output logic [CNT_W-1:0]  wbCount,
  output logic [1:0]        wbPos,
  output logic [BYTE_W-1:0] wbBytes
);

  iso_ssplit_pkg::ctrlStrobe_t strb;
  logic countNonZero;
  logic countIsOne;

  assign countNonZero = (inCount != '0);
  assign countIsOne   = (inCount == CNT_W'(1));

  iso_ssplit_ctrl #(.UF_N(UF_N), .UF_W(UF_W)) u_ctrl (
    .frameValid  (frameValid),
    .uframeIdx   (uframeIdx),
    .holdOff     (holdOff),
    .inActive    (inActive),
    .inMask      (inMask),
    .countNonZero(countNonZero),
    .countIsOne  (countIsOne),
    .strb        (strb)
  );

  iso_ssplit_dp #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .MAX_CHUNK(MAX_CHUNK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inActive(inActive),
    .inCount (inCount),
    .inPos   (inPos),
    .inBytes (inBytes),
    .ssIssue (ssIssue),
    .ssBytes (ssBytes),
    .ssPos   (ssPos),
    .skipErr (skipErr),
    .wbValid (wbValid),
    .wbActive(wbActive),
    .wbCount (wbCount),
    .wbPos   (wbPos),
    .wbBytes (wbBytes)
  );

endmodule

// File: rtl/iso_ssplit_seq_chk.sv
module iso_ssplit_seq_chk #(
  parameter int UF_N      = 8,
  parameter int BYTE_W    = 10,
  parameter int CNT_W     = 3,
  parameter int MAX_CHUNK = 188,
  parameter int UF_W      = $clog2(UF_N)
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic [UF_W-1:0]   uframeIdx,
  input logic              holdOff,
  input logic              inActive,
  input logic [UF_N-1:0]   inMask,
  input logic [CNT_W-1:0]  inCount,
  input logic [1:0]        inPos,
  input logic [BYTE_W-1:0] inBytes,
  input logic              ssIssue,
  input logic [BYTE_W-1:0] ssBytes,
  input logic [1:0]        ssPos,
  input logic              skipErr,
  input logic              wbValid,
  input logic              wbActive,
  input logic [CNT_W-1:0]  wbCount,
  input logic [1:0]        wbPos,
  input logic [BYTE_W-1:0] wbBytes
);

  assert_issue_needs_slot_R1: assert property (@(posedge clk) disable iff (!rstN)
    ssIssue |-> $past(frameValid && inActive && !holdOff && (inCount != '0) && inMask[uframeIdx]));

  assert_chunk_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    ssIssue |-> (ssBytes <= BYTE_W'(MAX_CHUNK)) && (ssBytes <= $past(inBytes)));

  assert_single_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ssIssue && ($past(inCount) == CNT_W'(1))) |-> (ssPos == 2'd0 || ssPos == 2'd3));

  assert_last_retires_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ssIssue && ($past(inCount) == CNT_W'(1))) |-> !wbActive && (wbCount == '0));

  assert_skip_no_issue_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ssIssue && skipErr));

  assert_skip_keeps_desc_R6: assert property (@(posedge clk) disable iff (!rstN)
    skipErr |-> (wbActive == $past(inActive)) && (wbCount == $past(inCount))
                && (wbBytes == $past(inBytes)) && (wbPos == $past(inPos)));

  assert_wb_follows_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> wbValid);

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wbValid |-> !ssIssue && !skipErr);

endmodule

bind iso_ssplit_seq iso_ssplit_seq_chk #(
  .UF_N(UF_N), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .MAX_CHUNK(MAX_CHUNK), .UF_W(UF_W)
) u_chk (.*);

// File: tb/iso_ssplit_seq_tb.sv
module iso_ssplit_seq_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit       act;
    bit [7:0] mask;
    int       cnt;
    int       pos;
    int       bytes;
  } desc_t;

  typedef struct {
    bit    issue;
    int    bytes;
    int    pos;
    bit    err;
    desc_t wb;
    string scen;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0;
  logic [2:0] uframeIdx = '0;
  logic       holdOff = 1'b0;
  logic       inActive = 1'b0;
  logic [7:0] inMask = '0;
  logic [2:0] inCount = '0;
  logic [1:0] inPos = '0;
  logic [9:0] inBytes = '0;
  logic       ssIssue, skipErr, wbValid, wbActive;
  logic [9:0] ssBytes, wbBytes;
  logic [1:0] ssPos, wbPos;
  logic [2:0] wbCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_ssplit_seq u_dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .uframeIdx(uframeIdx),
    .holdOff(holdOff), .inActive(inActive), .inMask(inMask), .inCount(inCount),
    .inPos(inPos), .inBytes(inBytes), .ssIssue(ssIssue), .ssBytes(ssBytes),
    .ssPos(ssPos), .skipErr(skipErr), .wbValid(wbValid), .wbActive(wbActive),
    .wbCount(wbCount), .wbPos(wbPos), .wbBytes(wbBytes)
  );

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Model built from the requirement list.
  function automatic exp_t model(desc_t d, int uf, bit hold, string scen);
    exp_t e;
    bit sel;
    int chunk;
    e.scen = scen; e.issue = 0; e.bytes = 0; e.pos = 0; e.err = 0; e.wb = d;
    sel = d.act && (d.cnt != 0) && d.mask[uf];
    if (sel && hold) begin
      e.err = 1;
    end else if (sel) begin
      chunk = (d.bytes > 188) ? 188 : d.bytes;
      e.issue = 1;
      e.bytes = chunk;
      e.wb.cnt = d.cnt - 1;
      e.wb.bytes = d.bytes - chunk;
      if (d.cnt == 1) begin
        e.pos = (d.pos == 0) ? 0 : 3;
        e.wb.act = 0;
        e.wb.pos = e.pos;
      end else begin
        e.pos = d.pos;
        e.wb.act = 1;
        e.wb.pos = (d.cnt - 1 == 1) ? 3 : 2;
      end
    end
    return e;
  endfunction

  // Driver: present one micro-frame, push expectation, carry write-back forward.
  task automatic frame(inout desc_t d, input int uf, input bit hold, input string scen);
    exp_t e;
    @(negedge clk);
    frameValid = 1'b1;
    uframeIdx  = 3'(uf);
    holdOff    = hold;
    inActive   = d.act;
    inMask     = d.mask;
    inCount    = 3'(d.cnt);
    inPos      = 2'(d.pos);
    inBytes    = 10'(d.bytes);
    e = model(d, uf, hold, scen);
    expQ.push_back(e);
    d = e.wb;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameValid = 1'b0;
      holdOff    = 1'b0;
    end
  endtask

  // Monitor: compare each write-back against the queued expectation.
  always @(negedge clk) begin
    if (rstN && wbValid) begin
      if (expQ.size() == 0) begin
        check("R9", "unexpected wbValid", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check({e.scen, "/R1"}, "ssIssue", int'(ssIssue), int'(e.issue));
        check({e.scen, "/R2"}, "ssBytes", int'(ssBytes), e.bytes);
        check({e.scen, "/R3"}, "ssPos", int'(ssPos), e.pos);
        check({e.scen, "/R6"}, "skipErr", int'(skipErr), int'(e.err));
        check({e.scen, "/R4"}, "wbCount", int'(wbCount), e.wb.cnt);
        check({e.scen, "/R4"}, "wbBytes", int'(wbBytes), e.wb.bytes);
        check({e.scen, "/R4"}, "wbPos", int'(wbPos), e.wb.pos);
        check({e.scen, "/R5"}, "wbActive", int'(wbActive), int'(e.wb.act));
      end
    end else if (rstN && !wbValid && (ssIssue || skipErr)) begin
      check("R9", "idle issue/err", int'(ssIssue || skipErr), 0);
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    desc_t d;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "reset wbValid", int'(wbValid), 0);
    check("R9", "reset ssIssue", int'(ssIssue), 0);
    check("R9", "reset skipErr", int'(skipErr), 0);
    rstN = 1'b1;
    idle(2);

    // R1 R2 R3 R4 R5: 400 bytes over three splits in slots 0..2
    d = '{act:1, mask:8'b0000_0111, cnt:3, pos:1, bytes:400};
    for (int uf = 0; uf < 8; uf++) frame(d, uf, 1'b0, "R4multi");
    idle(2);

    // R3 R5: single 100-byte split in slot 4 keeps ALL
    d = '{act:1, mask:8'b0001_0000, cnt:1, pos:0, bytes:100};
    for (int uf = 0; uf < 8; uf++) frame(d, uf, 1'b0, "R3single");
    idle(2);

    // R2: exactly 188 bytes, leaves zero
    d = '{act:1, mask:8'b1000_0000, cnt:1, pos:0, bytes:188};
    frame(d, 7, 1'b0, "R2edge");
    idle(2);

    // R6 R8: hold-off on slot 1, recovery at slot 5 with BEGIN
    d = '{act:1, mask:8'b0010_0010, cnt:2, pos:1, bytes:300};
    for (int uf = 0; uf < 8; uf++) frame(d, uf, (uf == 1), "R8skip");
    for (int uf = 0; uf < 8; uf++) frame(d, uf, 1'b0, "R8skip");
    idle(2);

    // R7: inactive descriptor and zero count ignore a full mask
    d = '{act:0, mask:8'hFF, cnt:2, pos:1, bytes:300};
    for (int uf = 0; uf < 4; uf++) frame(d, uf, 1'b0, "R7inactive");
    d = '{act:1, mask:8'hFF, cnt:0, pos:2, bytes:50};
    for (int uf = 0; uf < 4; uf++) frame(d, uf, 1'b0, "R7zero");
    idle(3);

    check("R9", "pending expectations", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule